// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits on the host side of a single-data-rate SDRAM device with sixteen data lines and four banks. It drives the chip-select, row-strobe, column-strobe and write-enable pins, the bank and address lines, and the write data lines. It also samples the read data lines. After reset it runs an initialisation sequence on its own: close every bank, two refresh cycles, then one mode-register load. Once that sequence ends it serves one user request at a time. Each request opens a row, performs a single-beat read or write with auto-precharge, and leaves every bank closed again. A free-running interval timer raises refresh requests, and an auto-refresh is issued at the first idle point after each one.

Every timing gap comes from a single down-counter. The counter is loaded with the ceiling of a nanosecond figure divided by the clock period, or with a fixed clock count. No-operation is driven while it is nonzero. The read data path uses a fixed CAS latency that is also written into the mode word.

The request port is a valid/ready stream. A request is taken on a cycle where both `req_valid` and `req_ready` are high. The requester must hold `req_valid` and its payload stable until that cycle. `req_ready` may fall and rise at any time, and it never depends on `req_valid`. The response side carries valid only and has no back-pressure: `rsp_valid` is a one-cycle strobe, and the consumer must take `rsp_rdata` on that cycle.

Top module: `sdram_seq`

## Requirements
- R1: While reset is held, the pins show no-operation, encoded as {cs_n,ras_n,cas_n,we_n}=0111. `sd_cke` is 1, and `req_ready`, `init_done`, `rsp_valid` and `sd_dq_oe` are all 0.
- R2: After reset the first non-NOP command is precharge (0010) with A10=1, meaning all banks. A refresh (0001) follows exactly tRP clocks later, a second refresh follows exactly tRC clocks after the first, and a mode load (0000) follows exactly tRC clocks after the second. tRP is ceil(20 ns/period) and tRC is ceil(70 ns/period).
- R3: The mode load drives BA=00 and address bits as follows: A2:A0=000 (burst of one), A3=0 (sequential), A6:A4 = the CAS latency (010 for 2, 011 for 3), A9=1 (single-beat writes), and A11, A10, A8, A7 all 0. With CAS latency 2 the word is 12'h220.
- R4: In the cycle after the mode load, the pins show NOP. `req_ready` is 0 during the mode-load cycle, and `init_done` is 1 from that cycle on.
- R5: `req_ready` is high only after initialisation, when no gap is running and no refresh is pending. An accepted request puts an activate (0011) on the pins in the next cycle.
- R6: The request address is split as bank = `req_addr[21:20]`, row = `req_addr[19:8]` and column = `req_addr[7:0]`. The activate drives the bank on BA and the row on A11:A0.
- R7: Exactly tRCD = ceil(20 ns/period) clocks after the activate, a write (0100) or read (0101) appears. It carries the same bank, the column on A7:A0, A10=1 for auto-precharge, and A11, A9 and A8 at 0.
- R8: `sd_dq_oe` is 1 only in the write-command cycle, and `sd_dq_out` then carries the request's write data.
- R9: For a read on the pins in cycle n, `sd_dq_in` is sampled at the end of cycle n+CL. `rsp_valid` is then high for cycle n+CL+1 only, with that sample on `rsp_rdata`.
- R10: After a read or write, the next non-NOP command comes no earlier than max(2+tRP, CL+tRP, tRC-tRCD) clocks later. The 2 is the write recovery. At a 4 ns period this gap is 13.
- R11: A refresh becomes pending every ceil(15.6 us/period) clocks, counted from reset. At the next idle point, a pending refresh is issued ahead of any waiting request. It is followed by a tRC gap.
- R12: Only the NOP, precharge, refresh, mode-load, activate, read and write encodings ever appear, and `sd_cke` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | {bank, row, column} |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data strobe, one cycle |
| rsp_rdata | output | 16 | Read data |
| init_done | output | 1 | Initialisation finished |
| sd_cke | output | 1 | Clock enable to device |
| sd_cs_n | output | 1 | Chip select, low active |
| sd_ras_n | output | 1 | Row strobe, low active |
| sd_cas_n | output | 1 | Column strobe, low active |
| sd_we_n | output | 1 | Write enable, low active |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Row / column / flag address |
| sd_dq_out | output | 16 | Write data to device |
| sd_dq_oe | output | 1 | Write data drive enable |
| sd_dq_in | input | 16 | Read data from device |

## Verification
A wrong gap count shows up at the pins as a command that arrives early or late. The bench measures every non-NOP command against the one before it, so this is caught within one command spacing, which is at most 18 clocks. A wrong latched bank, column or state is seen on the very next read or write command, either through its address pins or because the data read back does not match the bench's memory image. A broken read pipeline produces a response strobe off by a cycle, or carrying the filler value that the bench drives outside the valid data cycle. A stuck or mistimed refresh timer breaks the refresh window check about 3900 clocks after reset.

// File: rtl/sdc_pkg.sv
`timescale 1ns/1ps
package sdc_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_BST = 4'b0110,
    CMD_NOP = 4'b0111
  } sdc_cmd_e;

  typedef enum logic [2:0] {
    ST_PRE, ST_REF1, ST_REF2, ST_MRS, ST_IDLE, ST_RW
  } sdc_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdc_gap.sv
`timescale 1ns/1ps
module sdc_gap #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // a new gap may only start once the previous one has run out
  assert_load_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy);
endmodule

// File: rtl/sdc_refi.sv
`timescale 1ns/1ps
module sdc_refi #(
  parameter int PERIOD_CK = 3900
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pending
);
  localparam int CW = $clog2(PERIOD_CK + 1);
  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= CW'(PERIOD_CK - 1);
      pending <= 1'b0;
    end else begin
      cnt <= tick ? CW'(PERIOD_CK - 1) : cnt - 1'b1;
      if (tick)      pending <= 1'b1;
      else if (ack)  pending <= 1'b0;
    end
  end

  assert_pend_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack) |=> pending);
endmodule

// File: rtl/sdram_seq.sv
`timescale 1ns/1ps
module sdram_seq import sdc_pkg::*; #(
  parameter int CLK_PS       = 4000,
  parameter int T_RCD_NS     = 20,
  parameter int T_RP_NS      = 20,
  parameter int T_RC_NS      = 70,
  parameter int T_REFI_NS    = 15600,
  parameter int T_MRD_CK     = 2,
  parameter int T_WR_CK      = 2,
  parameter int CAS_LAT      = 2,
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 8,
  parameter int DATA_W       = 16,
  parameter int BURST_TYPE   = 0,
  parameter int WRITE_SINGLE = 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]               req_wdata,
  output logic                            rsp_valid,
  output logic [DATA_W-1:0]               rsp_rdata,
  output logic                            init_done,
  output logic                            sd_cke,
  output logic                            sd_cs_n,
  output logic                            sd_ras_n,
  output logic                            sd_cas_n,
  output logic                            sd_we_n,
  output logic [BANK_W-1:0]               sd_ba,
  output logic [ROW_W-1:0]                sd_addr,
  output logic [DATA_W-1:0]               sd_dq_out,
  output logic                            sd_dq_oe,
  input  logic [DATA_W-1:0]               sd_dq_in
);
  localparam int RCD_CK  = ceil_div(T_RCD_NS * 1000, CLK_PS);
  localparam int RP_CK   = ceil_div(T_RP_NS * 1000, CLK_PS);
  localparam int RC_CK   = ceil_div(T_RC_NS * 1000, CLK_PS);
  localparam int REFI_CK = ceil_div(T_REFI_NS * 1000, CLK_PS);
  localparam int POST_RW = imax(imax(T_WR_CK + RP_CK, CAS_LAT + RP_CK),
                                imax(RC_CK - RCD_CK, 1));
  localparam int MAX_GAP = imax(imax(RC_CK, POST_RW),
                                imax(RP_CK, imax(RCD_CK, T_MRD_CK)));
  localparam int CNT_W   = $clog2(MAX_GAP + 1);
  localparam int ROW_LO  = COL_W;
  localparam int BANK_LO = COL_W + ROW_W;

  logic [ROW_W-1:0] mode_word;
  always_comb begin
    mode_word      = '0;
    mode_word[2:0] = 3'b000;
    mode_word[3]   = 1'(BURST_TYPE);
    mode_word[6:4] = 3'(CAS_LAT);
    mode_word[9]   = 1'(WRITE_SINGLE);
  end

  sdc_state_e          st, st_n;
  sdc_cmd_e            cmd_q, cmd_n;
  logic [ROW_W-1:0]    addr_q, addr_n;
  logic [BANK_W-1:0]   ba_q, ba_n;
  logic [DATA_W-1:0]   dout_q, dout_n;
  logic                oe_q, oe_n;
  logic                done_q, done_n;
  logic                gap_load, gap_busy;
  logic [CNT_W-1:0]    gap_val;
  logic                ref_pend, ref_ack;
  logic                take, issue_rd;
  logic                lat_wr;
  logic [BANK_W-1:0]   lat_bank;
  logic [COL_W-1:0]    lat_col;
  logic [DATA_W-1:0]   lat_data;
  logic [CAS_LAT:0]    rd_pipe;

  sdc_gap #(.CNT_W(CNT_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .busy(gap_busy)
  );

  sdc_refi #(.PERIOD_CK(REFI_CK)) u_refi (
    .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pending(ref_pend)
  );

  assign req_ready = (st == ST_IDLE) && !gap_busy && !ref_pend;
  assign take      = req_valid && req_ready;

  always_comb begin
    st_n     = st;
    cmd_n    = CMD_NOP;
    addr_n   = '0;
    ba_n     = '0;
    dout_n   = '0;
    oe_n     = 1'b0;
    done_n   = done_q;
    gap_load = 1'b0;
    gap_val  = '0;
    ref_ack  = 1'b0;
    issue_rd = 1'b0;
    if (!gap_busy) begin
      unique case (st)
        ST_PRE: begin
          cmd_n = CMD_PRE; addr_n[10] = 1'b1;
          gap_load = 1'b1; gap_val = CNT_W'(RP_CK - 1); st_n = ST_REF1;
        end
        ST_REF1: begin
          cmd_n = CMD_REF; gap_load = 1'b1; gap_val = CNT_W'(RC_CK - 1); st_n = ST_REF2;
        end
        ST_REF2: begin
          cmd_n = CMD_REF; gap_load = 1'b1; gap_val = CNT_W'(RC_CK - 1); st_n = ST_MRS;
        end
        ST_MRS: begin
          cmd_n = CMD_MRS; addr_n = mode_word; done_n = 1'b1;
          gap_load = 1'b1; gap_val = CNT_W'(T_MRD_CK - 1); st_n = ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_pend) begin
            cmd_n = CMD_REF; ref_ack = 1'b1;
            gap_load = 1'b1; gap_val = CNT_W'(RC_CK - 1);
          end else if (take) begin
            cmd_n  = CMD_ACT;
            ba_n   = req_addr[BANK_LO +: BANK_W];
            addr_n = req_addr[ROW_LO +: ROW_W];
            gap_load = 1'b1; gap_val = CNT_W'(RCD_CK - 1); st_n = ST_RW;
          end
        end
        ST_RW: begin
          cmd_n  = lat_wr ? CMD_WR : CMD_RD;
          ba_n   = lat_bank;
          addr_n[COL_W-1:0] = lat_col;
          addr_n[10] = 1'b1;
          oe_n   = lat_wr;
          dout_n = lat_wr ? lat_data : '0;
          issue_rd = !lat_wr;
          gap_load = 1'b1; gap_val = CNT_W'(POST_RW - 1); st_n = ST_IDLE;
        end
        default: st_n = ST_PRE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_PRE; cmd_q <= CMD_NOP; addr_q <= '0; ba_q <= '0;
      dout_q <= '0; oe_q <= 1'b0; done_q <= 1'b0;
      lat_wr <= 1'b0; lat_bank <= '0; lat_col <= '0; lat_data <= '0;
    end else begin
      st <= st_n; cmd_q <= cmd_n; addr_q <= addr_n; ba_q <= ba_n;
      dout_q <= dout_n; oe_q <= oe_n; done_q <= done_n;
      if (take) begin
        lat_wr   <= req_write;
        lat_bank <= req_addr[BANK_LO +: BANK_W];
        lat_col  <= req_addr[COL_W-1:0];
        lat_data <= req_wdata;
      end
    end
  end

  // read return: capture CAS_LAT clocks after the read is on the pins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_pipe <= '0; rsp_valid <= 1'b0; rsp_rdata <= '0;
    end else begin
      rd_pipe   <= {rd_pipe[CAS_LAT-1:0], issue_rd};
      rsp_valid <= rd_pipe[CAS_LAT];
      if (rd_pipe[CAS_LAT]) rsp_rdata <= sd_dq_in;
    end
  end

  assign sd_cke    = 1'b1;
  assign sd_cs_n   = cmd_q[3];
  assign sd_ras_n  = cmd_q[2];
  assign sd_cas_n  = cmd_q[1];
  assign sd_we_n   = cmd_q[0];
  assign sd_ba     = ba_q;
  assign sd_addr   = addr_q;
  assign sd_dq_out = dout_q;
  assign sd_dq_oe  = oe_q;
  assign init_done = done_q;

  assert_mrs_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_MRS) |=> (cmd_q == CMD_NOP));
  assert_accept_act_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (cmd_q == CMD_ACT));
  assert_autopre_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_q == CMD_RD) || (cmd_q == CMD_WR)) |-> sd_addr[10]);
  assert_wdata_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (cmd_q == CMD_WR));
  assert_rsp_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_ref_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_REF) |=> (cmd_q == CMD_NOP));
  generate
    if (RCD_CK > 1) begin : g_act_chk
      assert_act_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_ACT) |=> (cmd_q == CMD_NOP));
    end
  endgenerate
endmodule

// File: tb/sim_sdram_seq.sv
`timescale 1ns/1ps
module sim_sdram_seq;
  localparam int RP = 5, RCD = 5, RC = 18, MRD = 2, CL = 2, POST = 13, REFI = 3900;
  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0, sd_dq_in = 16'hBAD0;
  logic req_ready, rsp_valid, init_done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [15:0] rsp_rdata, sd_dq_out;
  logic [1:0] sd_ba;
  logic [11:0] sd_addr;

  always #2 clk = ~clk;

  sdram_seq u0 (.clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_rdata, .init_done, .sd_cke, .sd_cs_n, .sd_ras_n, .sd_cas_n, .sd_we_n,
    .sd_ba, .sd_addr, .sd_dq_out, .sd_dq_oe, .sd_dq_in);

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // reference state
  logic [15:0] mem [int];
  int  q_addr[$], q_w[$], q_d[$];
  int  due_cyc[$], due_dat[$], rsp_cyc[$], rsp_dat[$];
  int  cur_addr, cur_w, cur_d;
  int  cyc = 0, phase = 0, last_cyc = 0, nref = 0, nacc = 0, ndone = 0;
  logic [3:0] last_c = C_NOP;

  function automatic logic [15:0] mem_rd(int key);
    return mem.exists(key) ? mem[key] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    logic [3:0] c;
    int gap;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (!rst_n) begin
      chk(c == C_NOP, "R1 cmd in reset", c, C_NOP);
      chk(!req_ready && !init_done && !rsp_valid && !sd_dq_oe && sd_cke,
          "R1 flags in reset", {req_ready, init_done, rsp_valid, sd_dq_oe, sd_cke}, 1);
    end else begin
      cyc++;
      // read data response check
      if (rsp_cyc.size() > 0 && rsp_cyc[0] == cyc) begin
        chk(rsp_valid == 1, "R9 rsp_valid", rsp_valid, 1);
        chk(rsp_rdata == 16'(rsp_dat[0]), "R9 rsp_rdata", rsp_rdata, rsp_dat[0]);
        void'(rsp_cyc.pop_front()); void'(rsp_dat.pop_front()); ndone++;
      end else chk(rsp_valid == 0, "R9 stray rsp_valid", rsp_valid, 0);
      // device data drive
      if (due_cyc.size() > 0 && due_cyc[0] == cyc) begin
        sd_dq_in = 16'(due_dat[0]); void'(due_cyc.pop_front()); void'(due_dat.pop_front());
      end else sd_dq_in = 16'hBAD0;
      chk(sd_cke == 1, "R12 cke", sd_cke, 1);
      if (c != C_WR) chk(sd_dq_oe == 0, "R8 oe outside write", sd_dq_oe, 0);
      if (c != C_NOP) begin
        gap = cyc - last_cyc;
        if (last_c == C_RD || last_c == C_WR) chk(gap >= POST, "R10 gap after access", gap, POST);
        if (last_c == C_MRS) chk(gap >= MRD, "R4 gap after mode load", gap, MRD);
        if (last_c == C_REF && phase == 4) chk(gap >= RC, "R11 gap after refresh", gap, RC);
        case (c)
          C_PRE: begin
            chk(phase == 0, "R2 precharge order", phase, 0);
            chk(sd_addr[10] == 1, "R2 precharge all", sd_addr[10], 1);
            phase = 1;
          end
          C_REF: begin
            if (phase == 1) begin chk(gap == RP, "R2 tRP before refresh", gap, RP); phase = 2; end
            else if (phase == 2) begin chk(gap == RC, "R2 tRC between refreshes", gap, RC); phase = 3; end
            else if (phase == 4) begin
              nref++;
              chk(cyc - nref*REFI >= -3 && cyc - nref*REFI <= 25, "R11 refresh timing",
                  cyc, nref*REFI);
            end else chk(0, "R2 refresh order", phase, 4);
          end
          C_MRS: begin
            chk(phase == 3, "R2 mode load order", phase, 3);
            chk(gap == RC, "R2 tRC before mode load", gap, RC);
            chk(sd_addr == 12'h220 && sd_ba == 2'b00, "R3 mode word", sd_addr, 12'h220);
            chk(req_ready == 0, "R4 ready in mode cycle", req_ready, 0);
            chk(init_done == 1, "R4 init_done", init_done, 1);
            phase = 4;
          end
          C_ACT: begin
            chk(phase == 4 && q_addr.size() > 0, "R5 activate with request", q_addr.size(), 1);
            if (q_addr.size() > 0) begin
              cur_addr = q_addr.pop_front(); cur_w = q_w.pop_front(); cur_d = q_d.pop_front();
              chk(sd_ba == 2'(cur_addr >> 20), "R6 activate bank", sd_ba, cur_addr >> 20);
              chk(sd_addr == 12'(cur_addr >> 8), "R6 activate row", sd_addr, (cur_addr >> 8) & 'hfff);
            end
          end
          C_WR, C_RD: begin
            chk(last_c == C_ACT && gap == RCD, "R7 tRCD", gap, RCD);
            chk(sd_addr == {4'b0100, 8'(cur_addr)}, "R7 column and A10", sd_addr,
                {4'b0100, 8'(cur_addr)});
            chk(sd_ba == 2'(cur_addr >> 20), "R7 bank", sd_ba, cur_addr >> 20);
            chk((c == C_WR) == (cur_w != 0), "R7 direction", c, cur_w ? C_WR : C_RD);
            if (c == C_WR) begin
              chk(sd_dq_oe == 1, "R8 oe on write", sd_dq_oe, 1);
              chk(sd_dq_out == 16'(cur_d), "R8 write data", sd_dq_out, cur_d);
              mem[cur_addr] = sd_dq_out; ndone++;
            end else begin
              due_cyc.push_back(cyc + CL);     due_dat.push_back(mem_rd(cur_addr));
              rsp_cyc.push_back(cyc + CL + 1); rsp_dat.push_back(mem_rd(cur_addr));
            end
          end
          default: chk(0, "R12 illegal command", c, C_NOP);
        endcase
        last_c = c; last_cyc = cyc;
      end
    end
  end

  task automatic send(bit w, int a, int d);
    @(negedge clk); #0.5;
    req_valid = 1; req_write = w; req_addr = 22'(a); req_wdata = 16'(d);
    while (!req_ready) begin @(negedge clk); #0.5; end
    q_addr.push_back(a & 'h3fffff); q_w.push_back(w); q_d.push_back(d & 'hffff); nacc++;
    @(posedge clk); #0.5;
    req_valid = 0;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #0.5 rst_n = 1;
    while (!init_done) @(negedge clk);
    // directed corners: lowest and highest bank/row/column
    send(1, 22'h000000, 16'h1234);
    send(1, 22'h3FFFFF, 16'hBEEF);
    send(0, 22'h000000, 0);
    send(0, 22'h3FFFFF, 0);
    send(1, 22'h1ABC05, 16'h5A5A);
    send(0, 22'h1ABC06, 0);           // same row, unwritten column
    send(0, 22'h1ABC05, 0);
    repeat (30) @(negedge clk);       // idle stretch
    for (int i = 0; i < 520; i++) begin
      int a;
      a = ((i % 4) << 20) | (((i * 13) & 'hfff) << 8) | ((i * 7) & 'hff);
      if (i % 3 == 2) send(0, ((i - 2) % 4 << 20) | ((((i - 2) * 13) & 'hfff) << 8) | (((i - 2) * 7) & 'hff), 0);
      else send(1, a, (i * 16'h9E37 + 3) & 'hffff);
      if (i % 50 == 0) repeat (i % 7) @(negedge clk);
    end
    repeat (60) @(negedge clk);
    chk(nref >= 2, "R11 refresh count", nref, 2);
    chk(ndone == nacc, "R5 all requests served", ndone, nacc);
    chk(q_addr.size() == 0 && rsp_cyc.size() == 0, "R9 queues drained", rsp_cyc.size(), 0);
    finish_run();
  end

  initial begin
    repeat (60000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule